// File: doc/BRIEF.md
# Backup-domain control register

This block holds one 32-bit control word for an always-on backup power island. The word turns the slow external crystal oscillator on and off, lets that oscillator be bypassed by an external clock, picks the source of the real-time-clock input, gates that clock, and carries a software reset for the whole island. A host reads and writes the word through a small request/ready port with one strobe per byte. The oscillators, the clock multiplexer and the timekeeping logic are outside the block. It only stores the control values and drives them out as decoded signals.

The block keeps its contents through a main system reset. Only the backup-island reset clears the word. Several guards stand on the write path:
- An external access-enable input must be high before any oscillator or clock field can change.
- The bypass bit can change only while the oscillator is off.
- The clock-source field can be set once and then stays fixed until the island is reset.

Accesses that come back-to-back are slowed by a small bus-timing state machine. Its states are `ST_IDLE`, `ST_RECENT`, `ST_HOLD` and `ST_GRANT`, and its transitions are:

| From | Condition | To |
|---|---|---|
| `ST_IDLE` | an access completes | `ST_RECENT` |
| `ST_IDLE` | no request | `ST_IDLE` |
| `ST_RECENT` | request arrives; first wait cycle | `ST_HOLD` (or `ST_GRANT` when only one wait is configured) |
| `ST_RECENT` | no request | `ST_IDLE` |
| `ST_HOLD` | counter reaches `WAIT_CYC-1` | `ST_GRANT` |
| `ST_HOLD` | otherwise | `ST_HOLD`, with the counter incremented |
| `ST_GRANT` | request held; access completes | `ST_RECENT` |
| `ST_GRANT` | request dropped | `ST_IDLE` |

Top module: `bkp_ctl_reg`

## Requirements
- R1: While `bkp_rst_n` is low, all control outputs are 0 and the stored word reads as 0x0000_0000.
- R2: A low pulse on `sys_rst_n` leaves every stored field and control output unchanged. It only returns the bus timing to `ST_IDLE`.
- R3: Bit positions in the word:
  - Reads at `REG_OFFSET` (0x20) return oscillator enable in bit 0 and the live `osc_ready_in` in bit 1.
  - Bypass is in bit 2, clock source in bits 9:8, RTC clock enable in bit 15 and island reset in bit 16.
  - Every other bit reads 0, and any other address reads 0.
- R4: Writes to bits 0, 2, 9:8 and 15 take effect only when `dom_access_en` is high. Otherwise those fields keep their values.
- R5: A write to bit 2 takes effect only if bit 0 was 0 before that write. Bit 0 itself updates in the same write.
- R6: Clock-source codes are 00 none, 01 external slow oscillator, 10 internal slow oscillator, 11 fast external clock divided by 128. Once the field is non-zero, writes to it are ignored.
- R7: Writing 1 to bit 16 needs no access enable. The bit stays 1 until it is written 0, and `domain_rst` follows it. While bit 16 is 1, or is being set, all other fields are held at 0 and writes to them are ignored.
- R8: Byte strobe `acc_be[n]` enables byte n. Bits 0 and 2 are in byte 0, bits 9:8 and 15 are in byte 1, and bit 16 is in byte 2. A byte-1 write changes the clock fields without changing byte 0.
- R9: An access arriving in the cycle right after a completed access sees `acc_ready` low for `WAIT_CYC` (3) cycles and then completes. An access after an idle cycle completes with no wait.
- R10: After bit 16 has been set and cleared, the clock-source field accepts one new non-zero value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bkp_rst_n | input | 1 | Backup-island reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low; affects bus timing only |
| acc_req | input | 1 | Access request, held until accepted |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte address |
| acc_be | input | 4 | Byte strobes |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for the current address |
| acc_ready | output | 1 | Access completes when high together with `acc_req` |
| dom_access_en | input | 1 | Write-access enable for protected fields |
| osc_ready_in | input | 1 | Oscillator-ready status |
| osc_enable | output | 1 | Slow external oscillator enable |
| osc_bypass | output | 1 | Oscillator bypass |
| rtc_sel | output | 2 | Clock-source code |
| rtc_clk_en | output | 1 | RTC clock enable |
| domain_rst | output | 1 | Backup-island software reset |

## Verification
The hardest condition to reach is a guarded write landing in the `ST_GRANT` cycle of a stall, which ends a chain of back-to-back accesses. In that cycle the ready output, the source lock and the island-reset hold all decide together what is stored. The stimulus reaches it by issuing write, read and write accesses with no idle cycle between them. It does this both with a source already locked and right after the island reset is cleared. A behavioural reference model tracks the stall count and every field, and compares against the design in every cycle.

// File: rtl/bkp_ctl_pkg.sv
package bkp_ctl_pkg;

    localparam int REG_W       = 32;
    localparam int POS_OSC_EN  = 0;
    localparam int POS_OSC_RDY = 1;
    localparam int POS_BYP     = 2;
    localparam int POS_SRC     = 8;
    localparam int POS_RTC_EN  = 15;
    localparam int POS_DOM_RST = 16;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'b00,
        SRC_LS_EXT = 2'b01,
        SRC_LS_INT = 2'b10,
        SRC_HS_DIV = 2'b11
    } rtc_src_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECENT,
        ST_HOLD,
        ST_GRANT
    } acc_st_e;

    typedef struct packed {
        logic     dom_rst;
        logic     rtc_en;
        rtc_src_e src;
        logic     byp;
        logic     osc_en;
    } ctl_fields_t;

endpackage

// File: rtl/bkp_wait_fsm.sv
module bkp_wait_fsm
    import bkp_ctl_pkg::*;
#(
    parameter int WAIT_CYC = 3
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic req,
    output logic ready
);

    localparam int CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

    acc_st_e          state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    // state register
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                state_nxt = req ? ST_RECENT : ST_IDLE;
            end
            ST_RECENT: begin
                if (req) begin
                    if (WAIT_CYC > 1) begin
                        state_nxt = ST_HOLD;
                        cnt_nxt   = CNT_W'(1);
                    end else begin
                        state_nxt = ST_GRANT;
                    end
                end else begin
                    state_nxt = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (cnt == CNT_LAST) begin
                    state_nxt = ST_GRANT;
                end else begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
            ST_GRANT: begin
                state_nxt = req ? ST_RECENT : ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_IDLE:   ready = 1'b1;
            ST_RECENT: ready = !req;
            ST_HOLD:   ready = 1'b0;
            ST_GRANT:  ready = 1'b1;
            default:   ready = 1'b1;
        endcase
    end

endmodule

// File: rtl/bkp_ctl_fields.sv
module bkp_ctl_fields
    import bkp_ctl_pkg::*;
#(
    parameter int N_LANES = REG_W / 8
) (
    input  logic               clk,
    input  logic               bkp_rst_n,
    input  logic [N_LANES-1:0] lane_we,
    input  logic [REG_W-1:0]   wdata,
    input  logic               unlock,
    output ctl_fields_t        q
);

    localparam int LANE_OSC = POS_OSC_EN / 8;
    localparam int LANE_RTC = POS_SRC / 8;
    localparam int LANE_DOM = POS_DOM_RST / 8;

    ctl_fields_t d;
    logic        dom_nxt;
    logic        hold;

    assign dom_nxt = lane_we[LANE_DOM] ? wdata[POS_DOM_RST] : q.dom_rst;
    assign hold    = q.dom_rst | dom_nxt;

    always_comb begin
        d         = q;
        d.dom_rst = dom_nxt;
        if (hold) begin
            d.osc_en = 1'b0;
            d.byp    = 1'b0;
            d.src    = SRC_NONE;
            d.rtc_en = 1'b0;
        end else begin
            if (lane_we[LANE_OSC] && unlock) begin
                if (!q.osc_en) begin
                    d.byp = wdata[POS_BYP];
                end
                d.osc_en = wdata[POS_OSC_EN];
            end
            if (lane_we[LANE_RTC] && unlock) begin
                d.rtc_en = wdata[POS_RTC_EN];
                if (q.src == SRC_NONE) begin
                    d.src = rtc_src_e'(wdata[POS_SRC+1:POS_SRC]);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge bkp_rst_n) begin
        if (!bkp_rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    logic unused_wbits;
    assign unused_wbits = ^{wdata[31:17], wdata[14:10], wdata[7:3], wdata[1], lane_we[N_LANES-1]};

endmodule

// File: rtl/bkp_ctl_reg.sv
module bkp_ctl_reg
    import bkp_ctl_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h20,
    parameter int              WAIT_CYC   = 3
) (
    input  logic                 clk,
    input  logic                 bkp_rst_n,
    input  logic                 sys_rst_n,
    input  logic                 acc_req,
    input  logic                 acc_wr,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [REG_W/8-1:0]   acc_be,
    input  logic [REG_W-1:0]     acc_wdata,
    output logic [REG_W-1:0]     acc_rdata,
    output logic                 acc_ready,
    input  logic                 dom_access_en,
    input  logic                 osc_ready_in,
    output logic                 osc_enable,
    output logic                 osc_bypass,
    output logic [1:0]           rtc_sel,
    output logic                 rtc_clk_en,
    output logic                 domain_rst
);

    localparam int N_LANES = REG_W / 8;

    logic               hit;
    logic               wr_fire;
    logic [N_LANES-1:0] lane_we;
    ctl_fields_t        fld;
    logic [REG_W-1:0]   rd_word;

    assign hit     = (acc_addr == REG_OFFSET);
    assign wr_fire = acc_req & acc_ready & acc_wr & hit;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        assign lane_we[i] = wr_fire & acc_be[i];
    end

    bkp_wait_fsm #(.WAIT_CYC(WAIT_CYC)) u_wait (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .req       (acc_req),
        .ready     (acc_ready)
    );

    bkp_ctl_fields #(.N_LANES(N_LANES)) u_fields (
        .clk       (clk),
        .bkp_rst_n (bkp_rst_n),
        .lane_we   (lane_we),
        .wdata     (acc_wdata),
        .unlock    (dom_access_en),
        .q         (fld)
    );

    always_comb begin
        rd_word                          = '0;
        rd_word[POS_OSC_EN]              = fld.osc_en;
        rd_word[POS_OSC_RDY]             = osc_ready_in;
        rd_word[POS_BYP]                 = fld.byp;
        rd_word[POS_SRC+1:POS_SRC]       = fld.src;
        rd_word[POS_RTC_EN]              = fld.rtc_en;
        rd_word[POS_DOM_RST]             = fld.dom_rst;
    end

    assign acc_rdata  = hit ? rd_word : '0;
    assign osc_enable = fld.osc_en;
    assign osc_bypass = fld.byp;
    assign rtc_sel    = fld.src;
    assign rtc_clk_en = fld.rtc_en;
    assign domain_rst = fld.dom_rst;

endmodule

// File: rtl/bkp_ctl_chk.sv
module bkp_ctl_chk #(
    parameter int WAIT_CYC = 3
) (
    input logic        clk,
    input logic        bkp_rst_n,
    input logic        sys_rst_n,
    input logic        acc_req,
    input logic        acc_ready,
    input logic [31:0] acc_rdata,
    input logic        dom_access_en,
    input logic        osc_enable,
    input logic        osc_bypass,
    input logic [1:0]  rtc_sel,
    input logic        rtc_clk_en,
    input logic        domain_rst
);

    localparam logic [31:0] RD_MASK = 32'h0001_8307;

    logic [7:0] stall_run;

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            stall_run <= '0;
        end else if (acc_req && !acc_ready) begin
            if (stall_run != 8'hFF) stall_run <= stall_run + 8'd1;
        end else begin
            stall_run <= '0;
        end
    end

    // R6
    src_lock_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        (rtc_sel != 2'b00) |=> ((rtc_sel == $past(rtc_sel)) || domain_rst));

    // R4
    prot_gate_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        !dom_access_en |=> ($stable({osc_enable, osc_bypass, rtc_sel, rtc_clk_en}) || domain_rst));

    // R5
    byp_gate_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        osc_enable |=> ($stable(osc_bypass) || domain_rst));

    // R7
    dom_hold_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        domain_rst |-> ({osc_enable, osc_bypass, rtc_sel, rtc_clk_en} == 5'b0));

    // R9
    stall_len_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (acc_req && !acc_ready) |-> (stall_run < 8'(WAIT_CYC)));

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        ((acc_rdata & ~RD_MASK) == 32'h0));

endmodule

bind bkp_ctl_reg bkp_ctl_chk #(.WAIT_CYC(WAIT_CYC)) u_chk (
    .clk           (clk),
    .bkp_rst_n     (bkp_rst_n),
    .sys_rst_n     (sys_rst_n),
    .acc_req       (acc_req),
    .acc_ready     (acc_ready),
    .acc_rdata     (acc_rdata),
    .dom_access_en (dom_access_en),
    .osc_enable    (osc_enable),
    .osc_bypass    (osc_bypass),
    .rtc_sel       (rtc_sel),
    .rtc_clk_en    (rtc_clk_en),
    .domain_rst    (domain_rst)
);

// File: tb/test_bkp_ctl_reg.sv
`timescale 1ns/1ps
module test_bkp_ctl_reg;

    localparam int          W   = 3;
    localparam logic [7:0]  OFF = 8'h20;

    logic        clk = 1'b0;
    logic        bkp_rst_n = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        acc_req = 1'b0;
    logic        acc_wr = 1'b0;
    logic [7:0]  acc_addr = OFF;
    logic [3:0]  acc_be = 4'h0;
    logic [31:0] acc_wdata = 32'h0;
    logic [31:0] acc_rdata;
    logic        acc_ready;
    logic        dom_access_en = 1'b0;
    logic        osc_ready_in = 1'b0;
    logic        osc_enable, osc_bypass, rtc_clk_en, domain_rst;
    logic [1:0]  rtc_sel;

    int    vectors = 0;
    int    fails   = 0;
    string phase   = "R1";

    always #2 clk = ~clk;

    bkp_ctl_reg i_bkp_ctl_reg (
        .clk(clk), .bkp_rst_n(bkp_rst_n), .sys_rst_n(sys_rst_n),
        .acc_req(acc_req), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_be(acc_be),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_ready(acc_ready),
        .dom_access_en(dom_access_en), .osc_ready_in(osc_ready_in),
        .osc_enable(osc_enable), .osc_bypass(osc_bypass), .rtc_sel(rtc_sel),
        .rtc_clk_en(rtc_clk_en), .domain_rst(domain_rst)
    );

    // reference model
    logic       m_prev = 1'b0;
    int         m_stall = 0;
    logic       m_oen = 1'b0, m_byp = 1'b0, m_ren = 1'b0, m_dr = 1'b0;
    logic [1:0] m_src = 2'b00;

    function automatic logic exp_ready();
        return (m_stall == 0) && !(m_prev && acc_req);
    endfunction

    always @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            m_prev  <= 1'b0;
            m_stall <= 0;
        end else begin
            m_prev <= acc_req && exp_ready();
            if (acc_req && !exp_ready())
                m_stall <= (m_stall == 0) ? W - 1 : m_stall - 1;
        end
    end

    always @(posedge clk or negedge bkp_rst_n) begin : model_fields
        logic fire;
        logic ndr;
        if (!bkp_rst_n) begin
            m_oen <= 1'b0; m_byp <= 1'b0; m_ren <= 1'b0; m_dr <= 1'b0; m_src <= 2'b00;
        end else begin
            fire = acc_req && acc_wr && exp_ready() && (acc_addr == OFF);
            ndr  = (fire && acc_be[2]) ? acc_wdata[16] : m_dr;
            if (m_dr || ndr) begin
                m_oen <= 1'b0; m_byp <= 1'b0; m_ren <= 1'b0; m_src <= 2'b00;
            end else if (fire && dom_access_en) begin
                if (acc_be[0]) begin
                    if (!m_oen) m_byp <= acc_wdata[2];
                    m_oen <= acc_wdata[0];
                end
                if (acc_be[1]) begin
                    m_ren <= acc_wdata[15];
                    if (m_src == 2'b00) m_src <= acc_wdata[9:8];
                end
            end
            m_dr <= ndr;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin : cmp
        logic [31:0] exp_rd;
        logic        bad;
        exp_rd = (acc_addr == OFF) ?
                 {15'b0, m_dr, m_ren, 5'b0, m_src, 5'b0, m_byp, osc_ready_in, m_oen} : 32'h0;
        bad = 1'b0;
        vectors++;
        if (acc_ready !== exp_ready()) begin
            $display("FAIL %s ready act=%b exp=%b t=%0t", phase, acc_ready, exp_ready(), $time); bad = 1'b1;
        end
        if (acc_rdata !== exp_rd) begin
            $display("FAIL %s rdata act=%h exp=%h t=%0t", phase, acc_rdata, exp_rd, $time); bad = 1'b1;
        end
        if ({osc_enable, osc_bypass, rtc_sel, rtc_clk_en, domain_rst} !==
            {m_oen, m_byp, m_src, m_ren, m_dr}) begin
            $display("FAIL %s outs act=%b exp=%b t=%0t", phase,
                     {osc_enable, osc_bypass, rtc_sel, rtc_clk_en, domain_rst},
                     {m_oen, m_byp, m_src, m_ren, m_dr}, $time);
            bad = 1'b1;
        end
        if (bad) fails++;
    end

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic access(input logic wr, input logic [3:0] be, input logic [31:0] d,
                          input logic [7:0] a);
        logic r;
        acc_req = 1'b1; acc_wr = wr; acc_be = be; acc_wdata = d; acc_addr = a;
        do begin
            @(negedge clk);
            r = acc_ready;
            @(posedge clk); #1;
        end while (!r);
        acc_req = 1'b0; acc_wr = 1'b0; acc_addr = OFF;
    endtask

    task automatic wr_gap(input logic [3:0] be, input logic [31:0] d);
        access(1'b1, be, d, OFF);
        idle(2);
    endtask

    initial begin
        phase = "R1";
        idle(3);
        bkp_rst_n = 1'b1; sys_rst_n = 1'b1;
        idle(2);

        phase = "R3";
        osc_ready_in = 1'b1; idle(2);
        access(1'b0, 4'hF, 32'h0, OFF); idle(1);
        access(1'b0, 4'hF, 32'h0, 8'h24); idle(1);
        osc_ready_in = 1'b0; idle(1);

        phase = "R4";
        dom_access_en = 1'b0;
        wr_gap(4'b0011, 32'h0000_8305);
        dom_access_en = 1'b1;
        wr_gap(4'b0011, 32'h0000_8105);

        phase = "R5";
        wr_gap(4'b0001, 32'h0000_0000);
        wr_gap(4'b0001, 32'h0000_0000);
        wr_gap(4'b0001, 32'h0000_0004);

        phase = "R6";
        wr_gap(4'b0010, 32'h0000_0300);

        phase = "R8";
        wr_gap(4'b0010, 32'h0000_8001);

        phase = "R2";
        sys_rst_n = 1'b0; idle(3);
        sys_rst_n = 1'b1; idle(2);

        phase = "R7";
        dom_access_en = 1'b0;
        wr_gap(4'b0100, 32'h0001_0000);
        dom_access_en = 1'b1;
        wr_gap(4'b0011, 32'h0000_8205);
        idle(4);
        wr_gap(4'b0111, 32'h0000_8205);

        phase = "R10";
        wr_gap(4'b0100, 32'h0000_0000);
        wr_gap(4'b0010, 32'h0000_0200);
        wr_gap(4'b0010, 32'h0000_8300);

        phase = "R9";
        access(1'b1, 4'b0001, 32'h0000_0001, OFF);
        access(1'b0, 4'hF, 32'h0, OFF);
        access(1'b1, 4'b0010, 32'h0000_0100, OFF);
        access(1'b1, 4'b0111, 32'h0001_0000, OFF);
        access(1'b1, 4'b0100, 32'h0000_0000, OFF);
        access(1'b1, 4'b0010, 32'h0000_8300, OFF);
        idle(2);
        access(1'b0, 4'hF, 32'h0, OFF);
        idle(2);

        phase = "R1";
        bkp_rst_n = 1'b0; idle(2);
        bkp_rst_n = 1'b1; idle(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule